// File: doc/BRIEF.md
# BCD Seven-Segment Decoder with Ripple Blanking

This block converts one binary-coded decimal digit into seven active-high segment drives for a numeric display. Two control inputs qualify the decode. An active-high show enable selects between normal decoding and the override modes. An active-low blanking input from the previous digit position selects zero suppression in normal mode, and selects lamp test or forced blank when the show enable is low. An active-low blanking output tells the next digit position whether suppression should continue.

Several instances are chained to suppress non-significant zeros across a multi-digit display. Each digit's blanking output feeds the next digit's blanking input. A zero stays dark only while every more significant digit was also a suppressed zero. With the show enable held low, all digits are driven together into lamp test or forced blank, and a pulse-width signal on that input can set brightness. A parameter adds an output register stage for timing closure.

Top module: `bcd_seg_blanker`

## Requirements
- R1: With show_en=0 and blank_in_n=0 (lamp test), seg is 7'b1111111 for every digit value and blank_out_n is 0.
- R2: With show_en=0 and blank_in_n=1, seg is 7'b0000000 for every digit value and blank_out_n is 1.
- R3: With show_en=1, blank_in_n=1 and digit=0, seg is 7'b1111110 (segments a to f lit, g dark) and blank_out_n is 1.
- R4: With show_en=1, blank_in_n=0 and digit=0, seg is 7'b0000000 and blank_out_n is 0, so suppression passes to the next position.
- R5: With show_en=1 and digit 1 to 9, the digit is shown whatever blank_in_n is, and blank_out_n is 1. The patterns in seg[6:0] are: 1=0110000, 2=1101101, 3=1111001, 4=0110011, 5=1011011, 6=0011111 (no top bar), 7=1110000, 8=1111111, 9=1110011 (no bottom bar).
- R6: With show_en=1 and digit 10 to 15, seg is 7'b0000000 and blank_out_n is 1, whatever blank_in_n is.
- R7: Segment order is seg[6]=a, seg[5]=b, seg[4]=c, seg[3]=d, seg[2]=e, seg[1]=f, seg[0]=g.
- R8: With REG_OUT=1, seg and blank_out_n follow the inputs one rising clock edge later. While rst is high at a rising edge, seg becomes 0 and blank_out_n becomes 1. With REG_OUT=0, the outputs are combinational and ignore clk and rst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset for the optional output register |
| digit | input | 4 | BCD digit to decode |
| show_en | input | 1 | High selects normal decoding; low selects lamp test or forced blank |
| blank_in_n | input | 1 | Active-low blanking request from the previous digit position |
| seg | output | 7 | Active-high segment drives, a in bit 6 to g in bit 0 |
| blank_out_n | output | 1 | Active-low blanking request to the next digit position |

## Verification
The only state is the optional output register. A wrong value there shows at the ports within one clock edge: a stale segment word, or a blanking output that breaks the suppression chain for the next digit. In combinational mode, a decode fault shows at once as a wrong segment word for one of the 64 input combinations. For that reason all 64 combinations are compared against an independent table, in both variants. The registered variant is also checked for exactly one edge of latency and for its reset value.

// File: rtl/bcd_seg_blanker.sv
module bcd_seg_blanker #(
  parameter bit REG_OUT = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] digit,
  input  logic       show_en,
  input  logic       blank_in_n,
  output logic [6:0] seg,
  output logic       blank_out_n
);

  logic [6:0] glyph;
  logic [6:0] seg_d;
  logic       bo_d;

  // bit 6 = a ... bit 0 = g
  always_comb begin
    case (digit)
      4'd0:    glyph = 7'b1111110;
      4'd1:    glyph = 7'b0110000;
      4'd2:    glyph = 7'b1101101;
      4'd3:    glyph = 7'b1111001;
      4'd4:    glyph = 7'b0110011;
      4'd5:    glyph = 7'b1011011;
      4'd6:    glyph = 7'b0011111;
      4'd7:    glyph = 7'b1110000;
      4'd8:    glyph = 7'b1111111;
      4'd9:    glyph = 7'b1110011;
      default: glyph = 7'b0000000;
    endcase
  end

  wire zero_sup = show_en && !blank_in_n && (digit == 4'd0);
  wire lamp     = !show_en && !blank_in_n;

  assign seg_d = lamp ? 7'h7F : (!show_en || zero_sup) ? 7'h00 : glyph;
  assign bo_d  = !(lamp || zero_sup);

  generate
    if (REG_OUT) begin : g_reg
      logic [6:0] seg_q;
      logic       bo_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          seg_q <= 7'h00;
          bo_q  <= 1'b1;
        end else begin
          seg_q <= seg_d;
          bo_q  <= bo_d;
        end
      end
      assign seg         = seg_q;
      assign blank_out_n = bo_q;

      assert_reset_blank_R8: assert property (@(posedge clk)
        rst |=> (seg == 7'h00 && blank_out_n));
      assert_lamp_test_R1: assert property (@(posedge clk) disable iff (rst)
        (!show_en && !blank_in_n) |=> (seg == 7'h7F && !blank_out_n));
      assert_forced_blank_R2: assert property (@(posedge clk) disable iff (rst)
        (!show_en && blank_in_n) |=> (seg == 7'h00 && blank_out_n));
      assert_zero_sup_R4: assert property (@(posedge clk) disable iff (rst)
        (show_en && !blank_in_n && digit == 4'd0) |=> (seg == 7'h00 && !blank_out_n));
      assert_illegal_blank_R6: assert property (@(posedge clk) disable iff (rst)
        (show_en && digit > 4'd9) |=> (seg == 7'h00 && blank_out_n));
      assert_digit_chain_R5: assert property (@(posedge clk) disable iff (rst)
        (show_en && digit != 4'd0 && digit <= 4'd9) |=> (blank_out_n && seg != 7'h00));
    end else begin : g_comb
      assign seg         = seg_d;
      assign blank_out_n = bo_d;

      assert_lamp_test_R1: assert property (@(posedge clk) disable iff (rst)
        (!show_en && !blank_in_n) |-> (seg == 7'h7F && !blank_out_n));
      assert_forced_blank_R2: assert property (@(posedge clk) disable iff (rst)
        (!show_en && blank_in_n) |-> (seg == 7'h00 && blank_out_n));
      assert_zero_sup_R4: assert property (@(posedge clk) disable iff (rst)
        (show_en && !blank_in_n && digit == 4'd0) |-> (seg == 7'h00 && !blank_out_n));
      assert_illegal_blank_R6: assert property (@(posedge clk) disable iff (rst)
        (show_en && digit > 4'd9) |-> (seg == 7'h00 && blank_out_n));
      assert_digit_chain_R5: assert property (@(posedge clk) disable iff (rst)
        (show_en && digit != 4'd0 && digit <= 4'd9) |-> (blank_out_n && seg != 7'h00));
    end
  endgenerate

endmodule

// File: tb/test_bcd_seg_blanker.sv
module test_bcd_seg_blanker;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] digit;
  logic       show_en;
  logic       blank_in_n;
  logic [6:0] seg_c, seg_r;
  logic       bo_c, bo_r;
  int         checks = 0;
  int         fails  = 0;
  bit         done   = 1'b0;

  always #10 clk = ~clk;

  bcd_seg_blanker #(.REG_OUT(1'b0)) i_bcd_seg_blanker (
    .clk(clk), .rst(rst), .digit(digit), .show_en(show_en),
    .blank_in_n(blank_in_n), .seg(seg_c), .blank_out_n(bo_c));

  bcd_seg_blanker #(.REG_OUT(1'b1)) i_bcd_seg_blanker_reg (
    .clk(clk), .rst(rst), .digit(digit), .show_en(show_en),
    .blank_in_n(blank_in_n), .seg(seg_r), .blank_out_n(bo_r));

  function automatic logic [7:0] expect_out(logic en, logic bin_n, logic [3:0] d);
    logic [6:0] s;
    if (!en) return bin_n ? {7'h00, 1'b1} : {7'h7F, 1'b0};
    if (d == 4'd0) return bin_n ? {7'b1111110, 1'b1} : {7'h00, 1'b0};
    case (d)
      4'd1: s = 7'b0110000;  4'd2: s = 7'b1101101;  4'd3: s = 7'b1111001;
      4'd4: s = 7'b0110011;  4'd5: s = 7'b1011011;  4'd6: s = 7'b0011111;
      4'd7: s = 7'b1110000;  4'd8: s = 7'b1111111;  4'd9: s = 7'b1110011;
      default: s = 7'h00;
    endcase
    return {s, 1'b1};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual seg=%b bo=%b expected seg=%b bo=%b",
               req, act[7:1], act[0], exp[7:1], exp[0]);
    end
  endtask

  // drive at negedge, then check combinational output, then registered after edge
  task automatic apply(string req, logic en, logic bin_n, logic [3:0] d);
    logic [7:0] prev_r;
    @(negedge clk);
    prev_r = {seg_r, bo_r};
    show_en = en; blank_in_n = bin_n; digit = d;
    #1;
    chk(req, {seg_c, bo_c}, expect_out(en, bin_n, d));
    @(posedge clk); #1;
    chk({req, " reg"}, {seg_r, bo_r}, expect_out(en, bin_n, d));
    if (prev_r == expect_out(en, bin_n, d)) ;
  endtask

  task automatic test_reset;
    rst = 1'b1; show_en = 1'b0; blank_in_n = 1'b0; digit = 4'd8;
    repeat (2) @(posedge clk);
    #1;
    chk("R8 reset value", {seg_r, bo_r}, {7'h00, 1'b1});
    chk("R1 comb ignores rst", {seg_c, bo_c}, {7'h7F, 1'b0});
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic test_lamp;
    for (int d = 0; d < 16; d += 5) apply("R1", 1'b0, 1'b0, 4'(d));
  endtask

  task automatic test_forced_blank;
    for (int d = 0; d < 16; d += 3) apply("R2", 1'b0, 1'b1, 4'(d));
  endtask

  task automatic test_zero;
    apply("R3", 1'b1, 1'b1, 4'd0);
    apply("R4", 1'b1, 1'b0, 4'd0);
  endtask

  task automatic test_digits;
    for (int d = 1; d <= 9; d++) begin
      apply("R5", 1'b1, 1'b0, 4'(d));
      apply("R5", 1'b1, 1'b1, 4'(d));
    end
    apply("R7 order segment a only top bar in 7", 1'b1, 1'b1, 4'd7);
    chk("R7", {seg_c[6], seg_c[0]}, {1'b1, 1'b0});
  endtask

  task automatic test_illegal;
    for (int d = 10; d < 16; d++) begin
      apply("R6", 1'b1, 1'b0, 4'(d));
      apply("R6", 1'b1, 1'b1, 4'(d));
    end
  endtask

  task automatic test_latency;
    apply("R8", 1'b1, 1'b1, 4'd2);
    @(negedge clk);
    digit = 4'd4; #1;
    chk("R8 holds before edge", {seg_r, bo_r}, expect_out(1'b1, 1'b1, 4'd2));
    chk("R8 comb immediate", {seg_c, bo_c}, expect_out(1'b1, 1'b1, 4'd4));
    @(posedge clk); #1;
    chk("R8 updates after edge", {seg_r, bo_r}, expect_out(1'b1, 1'b1, 4'd4));
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk("R8 sync reset", {seg_r, bo_r}, {7'h00, 1'b1});
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic test_sweep;
    for (int v = 0; v < 64; v++)
      apply("R1..R6 sweep", v[5], v[4], v[3:0]);
  endtask

  initial begin
    test_reset();
    test_lamp();
    test_forced_blank();
    test_zero();
    test_digits();
    test_illegal();
    test_latency();
    test_sweep();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule